// File: doc/BRIEF.md
# Host Controller Status and Interrupt Aggregator

This block keeps the interrupt status word of a host controller, along with a status-enable mask and a signal-enable mask. Seven status bits record events: internal error, sequence cancel, stall warning, sequence timeout, scheduled-command missed tick, transfer abort and transfer error. Five status bits are level flags that come from queue threshold conditions. The block works out each threshold condition from the queue's fill level and its programmed threshold. The command-ready and response-ready indications are the command and response threshold flags.

The command and transmit queues drain, so their flag compares free entries, which is `QDEPTH - level`. The response, interrupt-status and receive queues fill, so their flag compares used entries. A queue flush would otherwise make a draining queue look empty and raise its flag. To stop this, each queue has a two-state mute machine. State `Q_ARMED` passes the flag through. A flush strobe (transition `ARM_TO_MUTE`) enters `Q_MUTED`, which blocks the flag. The queue returns to `Q_ARMED` (transition `MUTE_TO_ARM`) on the first clock edge at which its raw condition is false and no flush is present. Otherwise it holds (`MUTE_HOLD`, `ARM_HOLD`).

A write to either enable register acts on the same clock edge as the write. The status word and the registered interrupt line therefore already reflect the new mask in the cycle after the write.

Top module: `irq_agg`

## Requirements
- R1: After reset, the status word, both enable masks and `irq_o` are all zero.
- R2: If an event's status-enable bit is clear, the event does not set its status bit (bits 0..6 = internal error, sequence cancel, stall warning, timeout, missed tick, transfer abort, transfer error).
- R3: An enabled event sets its status bit at the next clock edge, and the bit stays set after the event goes away.
- R4: A clear write (`clr_we_i`) with a 1 in an event bit clears that bit. If the event is present on the same edge, the bit stays set.
- R5: If a status-enable write sets a bit while its condition is true (event present or threshold met), the status bit is updated on that same edge.
- R6: `irq_o` is a register equal to the OR of (status AND signal-enable). It stays low when no set status bit has its signal-enable set.
- R7: If a signal-enable write sets a bit while its status bit is already set, `irq_o` is high in the cycle after the write.
- R8: The draining queues (index 0 command → status bit 7, index 3 transmit → bit 10) flag when `QDEPTH - level >= threshold`.
- R9: The filling queues (index 1 response → bit 8, index 2 interrupt-status → bit 9, index 4 receive → bit 11) flag when `level >= threshold`.
- R10: Threshold status bits follow their live condition, and clear writes have no effect on them.
- R11: After a queue flush strobe, that queue's threshold bit stays low until the raw condition has been seen false at a clock edge. Only after that does the queue flag again.
- R12: Clearing a status-enable bit drops a threshold bit, but leaves an already set event bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | Raw event conditions, bits 0..6 |
| q_level_i | input | 5*LW | Fill level of each queue, queue q at [q*LW +: LW] |
| q_thr_i | input | 5*LW | Threshold of each queue, same layout |
| q_flush_i | input | 5 | Per-queue flush strobe |
| sten_we_i | input | 1 | Status-enable write strobe |
| sten_wdata_i | input | 12 | Status-enable write data |
| sigen_we_i | input | 1 | Signal-enable write strobe |
| sigen_wdata_i | input | 12 | Signal-enable write data |
| clr_we_i | input | 1 | Status write-one-to-clear strobe |
| clr_wdata_i | input | 12 | Bits to clear |
| status_o | output | 12 | Status word |
| irq_o | output | 1 | Registered interrupt line |

## Verification
A mute machine stuck in `Q_MUTED` makes its threshold bit stay at zero after the queue crosses its threshold again. A machine that never mutes lets a flushed draining queue raise its bit in the cycle after the flush. A mask that is applied one cycle late shows as a status or `irq_o` value one cycle behind the enable write. Each of these faults appears at `status_o` or `irq_o` within one or two cycles of the stimulus that should trigger it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    parameter int NQ  = 5;
    parameter int NEV = 7;
    parameter int NS  = NEV + NQ;
    // queue indices; bit q of DRAIN_MASK marks a queue that is checked on free entries
    parameter logic [NQ-1:0] DRAIN_MASK = 5'b01001;
    // status bits at and above NEV are level flags
    parameter logic [NS-1:0] LEVEL_MASK = {{NQ{1'b1}}, {NEV{1'b0}}};

    typedef enum logic [0:0] {
        Q_ARMED = 1'b0,
        Q_MUTED = 1'b1
    } qmute_e;
endpackage

// File: rtl/irq_qthr.sv
module irq_qthr
    import irq_agg_pkg::*;
#(
    parameter int  QDEPTH = 16,
    parameter int  LW     = $clog2(QDEPTH + 1),
    parameter bit  DRAIN  = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [LW-1:0] level_i,
    input  logic [LW-1:0] thr_i,
    input  logic          flush_i,
    output logic          flag_o
);
    localparam logic [LW-1:0] DEPTH_W = LW'(QDEPTH);

    logic [LW-1:0] count;
    logic          raw;
    qmute_e        state_q, state_d;

    generate
        if (DRAIN) begin : g_free
            assign count = DEPTH_W - level_i;
        end else begin : g_used
            assign count = level_i;
        end
    endgenerate

    assign raw = (count >= thr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= Q_ARMED;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_ARMED: if (flush_i) state_d = Q_MUTED;
            Q_MUTED: if (!flush_i && !raw) state_d = Q_ARMED;
            default: state_d = Q_ARMED;
        endcase
    end

    always_comb begin
        flag_o = 1'b0;
        unique case (state_q)
            Q_ARMED: flag_o = raw & ~flush_i;
            Q_MUTED: flag_o = 1'b0;
            default: flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_stat_core.sv
module irq_stat_core
    import irq_agg_pkg::*;
#(
    parameter int NBITS = NS,
    parameter logic [NBITS-1:0] LVL = LEVEL_MASK
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NBITS-1:0] cond_i,
    input  logic             sten_we_i,
    input  logic [NBITS-1:0] sten_wdata_i,
    input  logic             sigen_we_i,
    input  logic [NBITS-1:0] sigen_wdata_i,
    input  logic             clr_we_i,
    input  logic [NBITS-1:0] clr_wdata_i,
    output logic [NBITS-1:0] status_o,
    output logic [NBITS-1:0] sten_o,
    output logic [NBITS-1:0] sigen_o,
    output logic             irq_o
);
    logic [NBITS-1:0] sten_q, sten_d;
    logic [NBITS-1:0] sig_q, sig_d;
    logic [NBITS-1:0] stat_q, stat_d;
    logic [NBITS-1:0] clr_m;
    logic             irq_q;

    // a mask write acts on the edge it arrives, so use its next value
    assign sten_d = sten_we_i  ? sten_wdata_i  : sten_q;
    assign sig_d  = sigen_we_i ? sigen_wdata_i : sig_q;
    assign clr_m  = clr_we_i   ? clr_wdata_i   : '0;

    generate
        for (genvar i = 0; i < NBITS; i++) begin : g_bit
            if (LVL[i]) begin : g_lvl
                assign stat_d[i] = cond_i[i] & sten_d[i];
            end else begin : g_evt
                assign stat_d[i] = (stat_q[i] & ~clr_m[i]) | (cond_i[i] & sten_d[i]);
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sten_q <= '0;
            sig_q  <= '0;
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            sten_q <= sten_d;
            sig_q  <= sig_d;
            stat_q <= stat_d;
            irq_q  <= |(stat_d & sig_d);
        end
    end

    assign status_o = stat_q;
    assign sten_o   = sten_q;
    assign sigen_o  = sig_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter  int QDEPTH = 16,
    localparam int LW     = $clog2(QDEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NEV-1:0]   evt_i,
    input  logic [NQ*LW-1:0] q_level_i,
    input  logic [NQ*LW-1:0] q_thr_i,
    input  logic [NQ-1:0]    q_flush_i,
    input  logic             sten_we_i,
    input  logic [NS-1:0]    sten_wdata_i,
    input  logic             sigen_we_i,
    input  logic [NS-1:0]    sigen_wdata_i,
    input  logic             clr_we_i,
    input  logic [NS-1:0]    clr_wdata_i,
    output logic [NS-1:0]    status_o,
    output logic             irq_o
);
    logic [NQ-1:0] qflag;
    logic [NS-1:0] sten_w;
    logic [NS-1:0] sigen_w;

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_q
            irq_qthr #(
                .QDEPTH (QDEPTH),
                .LW     (LW),
                .DRAIN  (DRAIN_MASK[q])
            ) u_thr (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .level_i (q_level_i[q*LW +: LW]),
                .thr_i   (q_thr_i[q*LW +: LW]),
                .flush_i (q_flush_i[q]),
                .flag_o  (qflag[q])
            );
        end
    endgenerate

    irq_stat_core #(
        .NBITS (NS),
        .LVL   (LEVEL_MASK)
    ) u_core (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .cond_i        ({qflag, evt_i}),
        .sten_we_i     (sten_we_i),
        .sten_wdata_i  (sten_wdata_i),
        .sigen_we_i    (sigen_we_i),
        .sigen_wdata_i (sigen_wdata_i),
        .clr_we_i      (clr_we_i),
        .clr_wdata_i   (clr_wdata_i),
        .status_o      (status_o),
        .sten_o        (sten_w),
        .sigen_o       (sigen_w),
        .irq_o         (irq_o)
    );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [NEV-1:0] evt,
    input logic [NQ-1:0] flush,
    input logic          clr_we,
    input logic [NS-1:0] clr_wdata,
    input logic [NS-1:0] status,
    input logic [NS-1:0] sten,
    input logic [NS-1:0] sigen,
    input logic          irq
);
    generate
        for (genvar i = 0; i < NEV; i++) begin : g_e
            a_r2_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(status[i]) |-> ($past(evt[i]) && sten[i]));
            a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(status[i]) && !($past(clr_we) && $past(clr_wdata[i]))) |-> status[i]);
            a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(clr_we) && $past(clr_wdata[i]) && !$past(evt[i])) |-> !status[i]);
        end
        for (genvar j = 0; j < NQ; j++) begin : g_l
            a_r12_level_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
                status[NEV+j] |-> sten[NEV+j]);
            a_r11_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                $past(flush[j]) |-> !status[NEV+j]);
        end
    endgenerate

    a_r6_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(status & sigen)));
endmodule

bind irq_agg irq_agg_chk u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .evt       (evt_i),
    .flush     (q_flush_i),
    .clr_we    (clr_we_i),
    .clr_wdata (clr_wdata_i),
    .status    (status_o),
    .sten      (sten_w),
    .sigen     (sigen_w),
    .irq       (irq_o)
);

// File: tb/sim_irq_agg.sv
`timescale 1ns/1ps
module sim_irq_agg;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    evt = '0;
    logic [24:0]   lvl = '0;
    logic [24:0]   thr = '0;
    logic [4:0]    flush = '0;
    logic          sten_we = 1'b0, sig_we = 1'b0, clr_we = 1'b0;
    logic [11:0]   sten_wd = '0, sig_wd = '0, clr_wd = '0;
    logic [11:0]   status;
    logic          irq;

    always #2.5 clk = ~clk;

    irq_agg u0 (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .q_level_i(lvl), .q_thr_i(thr),
        .q_flush_i(flush), .sten_we_i(sten_we), .sten_wdata_i(sten_wd),
        .sigen_we_i(sig_we), .sigen_wdata_i(sig_wd), .clr_we_i(clr_we),
        .clr_wdata_i(clr_wd), .status_o(status), .irq_o(irq)
    );

    typedef struct {
        logic [11:0] st;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // monitor: one expectation per cycle, compared after the edge it belongs to
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (status !== e.st || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                             e.tag, status, irq, e.st, e.irq);
                end
            end
        end
    end

    task automatic set_lvl(int q, int v);
        lvl[q*LW +: LW] = LW'(v);
    endtask

    // driver: inputs already set; push what the next edge must produce, then release strobes
    task automatic expect_next(logic [11:0] st, logic i, string tag);
        exp_t e;
        e.st = st; e.irq = i; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk); #1;
        sten_we = 0; sig_we = 0; clr_we = 0; flush = '0;
    endtask

    initial begin
        for (int q = 0; q < 5; q++) thr[q*LW +: LW] = 5'd4;
        set_lvl(0, 16); set_lvl(3, 16);
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        expect_next(12'h000, 0, "R1 reset state");
        // R2 disabled event
        evt[0] = 1; expect_next(12'h000, 0, "R2 disabled event");
        evt = '0;
        // R5 enable while event present
        sten_we = 1; sten_wd = 12'h07F; evt[1] = 1;
        expect_next(12'h002, 0, "R5 enable with event held");
        evt = '0; expect_next(12'h002, 0, "R3 sticky");
        evt[2] = 1; expect_next(12'h006, 0, "R3 second event");
        evt = '0;
        clr_we = 1; clr_wd = 12'h002; expect_next(12'h004, 0, "R4 clear");
        clr_we = 1; clr_wd = 12'h004; evt[2] = 1; expect_next(12'h004, 0, "R4 set wins");
        evt = '0; expect_next(12'h004, 0, "R6 no signal enable");
        sig_we = 1; sig_wd = 12'h004; expect_next(12'h004, 1, "R7 signal enable on set bit");
        clr_we = 1; clr_wd = 12'h004; expect_next(12'h000, 0, "R6 irq drops");
        sten_we = 1; sten_wd = 12'hFFF; expect_next(12'h000, 0, "R8 idle queues");
        set_lvl(0, 12); expect_next(12'h080, 0, "R8 cmd free 4");
        set_lvl(0, 13); expect_next(12'h000, 0, "R10 cmd free 3");
        set_lvl(0, 16); set_lvl(3, 12); expect_next(12'h400, 0, "R8 tx free 4");
        set_lvl(3, 16); set_lvl(1, 4); expect_next(12'h100, 0, "R9 resp used 4");
        set_lvl(1, 3); expect_next(12'h000, 0, "R9 resp used 3");
        set_lvl(2, 5); set_lvl(4, 4); expect_next(12'hA00, 0, "R9 ibi and rx");
        clr_we = 1; clr_wd = 12'hA00; expect_next(12'hA00, 0, "R10 clear ignored");
        sten_we = 1; sten_wd = 12'h7FF; expect_next(12'h200, 0, "R12 level drops");
        sten_we = 1; sten_wd = 12'hFFF; expect_next(12'hA00, 0, "R5 level enable");
        set_lvl(1, 0); set_lvl(2, 0); set_lvl(4, 0); expect_next(12'h000, 0, "R10 levels gone");
        // R11 flush of draining command queue
        flush[0] = 1; expect_next(12'h000, 0, "R11 flush edge");
        set_lvl(0, 0); expect_next(12'h000, 0, "R11 muted after flush");
        expect_next(12'h000, 0, "R11 still muted");
        set_lvl(0, 16); expect_next(12'h000, 0, "R11 rearm");
        set_lvl(0, 12); expect_next(12'h080, 0, "R11 flags after rearm");
        sig_we = 1; sig_wd = 12'h080; expect_next(12'h080, 1, "R7 level signal");
        set_lvl(0, 16); expect_next(12'h000, 0, "R6 irq with level");
        // R12 event keeps state when its enable is cleared
        evt[5] = 1; expect_next(12'h020, 0, "R3 abort event");
        evt = '0; sten_we = 1; sten_wd = 12'hFDF; expect_next(12'h020, 0, "R12 event kept");
        clr_we = 1; clr_wd = 12'h020; expect_next(12'h000, 0, "R4 clear abort");
        evt[5] = 1; expect_next(12'h000, 0, "R2 disabled abort");
        evt = '0;
        repeat (2) @(negedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule